// File: doc/BRIEF.md
# Reset Line Active Pullup Controller

This block drives the enable of a P-channel transistor placed in parallel with the passive resistor on a shared, wired-low reset line. Several devices can pull that line low. When they let go, the resistor alone charges the line's capacitance slowly. The block switches the transistor on for a short, bounded part of the rising edge so that the line reaches a valid high level quickly.

Two analog comparators watch the line. One reports that the line is above a low threshold. The other reports that it is above 85 % of the supply. The block resynchronises and filters both comparator outputs. It records that the line has been low, which arms it. On the next rise through the low threshold it turns the pullup on. The pullup turns off again when the line reaches the upper threshold, or when a one-shot of about 2 µs runs out, whichever happens first. The one-shot is counted in clock cycles. A status output shows that the last pulse ended on the timeout and not on the upper threshold.

Top module: `line_boost_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, `boost_en_o` and `boost_tmo_o` are 0 and the block is not armed. The filtered comparator levels reset to 1, meaning the line is high.
- R2: While the filtered low-threshold level is 0, the block is armed, and `boost_en_o` is 0 from the next clock on.
- R3: When the block is armed, the low-threshold level is 1 and the high-threshold level is 0, `boost_en_o` rises on the next clock.
- R4: A pulse during which the filtered high-threshold level becomes 1 ends on the next clock, and `boost_tmo_o` stays 0.
- R5: A pulse that never sees the high threshold lasts exactly PULSE_CYCLES clocks. PULSE_CYCLES = ceil(PULSE_NS·1000 / CLK_PERIOD_PS), which is 500 at the defaults of 2000 ns and 4000 ps. After such a pulse `boost_tmo_o` is 1.
- R6: Every pulse end disarms the block. A later fall of the line that stays above the low threshold does not start another pulse.
- R7: If the line is pulled below the low threshold during a pulse, the pulse stops and the block re-arms. The next rise starts a fresh full-length pulse.
- R8: If an armed line jumps past both thresholds at once, no pulse is produced and the block disarms.
- R9: Each comparator input passes two synchronising flops. The filtered level then takes a new value only when two successive synchronised samples agree, which gives 4 clocks from an input change to a filtered change. A single-cycle glitch has no effect.
- R10: `boost_tmo_o` keeps its value until the next pulse starts. It reads 0 from the first cycle of that pulse.
- R11: `boost_en_o` is never 1 in the cycle after the filtered low-threshold level was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that times the one-shot |
| rst_ni | input | 1 | Asynchronous reset, active low |
| above_lo_i | input | 1 | Raw comparator: line above the low threshold |
| above_hi_i | input | 1 | Raw comparator: line above 0.85 × supply |
| boost_en_o | output | 1 | Enable for the parallel P-channel pullup |
| boost_tmo_o | output | 1 | Last pulse was ended by the one-shot timeout |

## Verification
The bench tries the main function with several patterns. A slow rise that never reaches the upper comparator shows the full timeout length and sets the status bit. A rise that reaches the upper comparator after 100 clocks separates the threshold exit from the timeout exit. A line pulled low again mid-pulse shows the abort and re-arm. A rise that crosses both thresholds together shows that no pulse is produced. A drop that stays between the thresholds after a completed pulse shows that the block has disarmed. Glitches of one and two cycles on the low comparator separate the filter's rejection from a real fall. A cycle-level behavioural model is compared with both outputs on every clock.

// File: rtl/lb_pkg.sv
package lb_pkg;

    typedef struct packed {
        logic armed;
        logic en;
        logic tmo;
    } lb_ctrl_t;

    localparam int unsigned LB_NUM_COMP = 2;
    localparam int unsigned LB_IDX_LO   = 0;
    localparam int unsigned LB_IDX_HI   = 1;

endpackage

// File: rtl/lb_input_filter.sv
module lb_input_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        RST_VAL     = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic level_o
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [MSB:0] sync;
        logic         prev;
        logic         level;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[MSB-1:0], raw_i};
        st_d.prev = st_q.sync[MSB];
        if (st_q.sync[MSB] == st_q.prev) begin
            st_d.level = st_q.sync[MSB];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{sync: {SYNC_STAGES{RST_VAL}}, prev: RST_VAL, level: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;

endmodule

// File: rtl/lb_pulse_timer.sv
module lb_pulse_timer #(
    parameter int unsigned PULSE_CYCLES = 500,
    localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic run_i,
    output logic last_o
);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(PULSE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = '0;
        end else if (run_i && (cnt_q != LAST_VAL)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == LAST_VAL);

endmodule

// File: rtl/line_boost_ctrl.sv
module line_boost_ctrl
    import lb_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned PULSE_NS      = 2000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic above_lo_i,
    input  logic above_hi_i,
    output logic boost_en_o,
    output logic boost_tmo_o
);
    localparam int unsigned PULSE_CYCLES =
        (PULSE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    logic [LB_NUM_COMP-1:0] raw;
    logic [LB_NUM_COMP-1:0] lvl;
    logic                   lo_f, hi_f;
    logic                   tmr_start, tmr_last;
    lb_ctrl_t               ctl_d, ctl_q;

    assign raw[LB_IDX_LO] = above_lo_i;
    assign raw[LB_IDX_HI] = above_hi_i;

    for (genvar g = 0; g < LB_NUM_COMP; g++) begin : g_filt
        lb_input_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .RST_VAL     (1'b1)
        ) u_filt (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .raw_i   (raw[g]),
            .level_o (lvl[g])
        );
    end

    assign lo_f = lvl[LB_IDX_LO];
    assign hi_f = lvl[LB_IDX_HI];

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        if (!lo_f) begin
            ctl_d.armed = 1'b1;
            ctl_d.en    = 1'b0;
        end else if (ctl_q.en) begin
            if (hi_f) begin
                ctl_d.en    = 1'b0;
                ctl_d.armed = 1'b0;
            end else if (tmr_last) begin
                ctl_d.en    = 1'b0;
                ctl_d.armed = 1'b0;
                ctl_d.tmo   = 1'b1;
            end
        end else if (ctl_q.armed) begin
            if (hi_f) begin
                ctl_d.armed = 1'b0;
            end else begin
                ctl_d.en  = 1'b1;
                ctl_d.tmo = 1'b0;
                tmr_start = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lb_pulse_timer #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (tmr_start),
        .run_i   (ctl_q.en),
        .last_o  (tmr_last)
    );

    assign boost_en_o  = ctl_q.en;
    assign boost_tmo_o = ctl_q.tmo;

endmodule

// File: rtl/line_boost_ctrl_chk.sv
module line_boost_ctrl_chk #(
    parameter int unsigned PULSE_CYCLES = 500
) (
    input logic clk_i,
    input logic rst_ni,
    input logic lo_f,
    input logic hi_f,
    input logic armed,
    input logic en,
    input logic tmo
);
    logic [31:0] run_len_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_len_q <= '0;
        end else if (en) begin
            run_len_q <= run_len_q + 1;
        end else begin
            run_len_q <= '0;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk_i)
        !rst_ni |=> (!en && !tmo));

    a_r2_arm_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lo_f |=> armed);

    a_r11_no_drive_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lo_f |=> !en);

    a_r3_turn_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && !en && lo_f && !hi_f) |=> en);

    a_r4_off_at_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en && lo_f && hi_f) |=> (!en && !tmo));

    a_r5_bounded_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en |-> (run_len_q < PULSE_CYCLES));

    a_r5_ends_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en && (run_len_q == PULSE_CYCLES - 1)) |=> !en);

    a_r6_disarm_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en && lo_f) |=> (en || !armed));

    a_r10_tmo_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(en) |-> !tmo);

endmodule

bind line_boost_ctrl line_boost_ctrl_chk #(
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lo_f   (lo_f),
    .hi_f   (hi_f),
    .armed  (ctl_q.armed),
    .en     (ctl_q.en),
    .tmo    (ctl_q.tmo)
);

// File: tb/line_boost_ctrl_tb.sv
`timescale 1ns/1ps
module line_boost_ctrl_tb;

    localparam int PULSE = (2000 * 1000 + 4000 - 1) / 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lo_in = 1'b1;
    logic hi_in = 1'b1;
    logic en, tmo;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2 clk = ~clk;

    line_boost_ctrl u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .above_lo_i  (lo_in),
        .above_hi_i  (hi_in),
        .boost_en_o  (en),
        .boost_tmo_o (tmo)
    );

    // behavioural reference model
    bit lo_hist[$];
    bit hi_hist[$];
    bit m_lo, m_hi, m_arm, m_en, m_tmo;
    int m_len;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_hist = '{1, 1, 1};
            hi_hist = '{1, 1, 1};
            m_lo = 1; m_hi = 1; m_arm = 0; m_en = 0; m_tmo = 0; m_len = 0;
        end else begin
            if (!m_lo) begin
                m_arm = 1; m_en = 0;
            end else if (m_en) begin
                if (m_hi) begin
                    m_en = 0; m_arm = 0;
                end else if (m_len == PULSE - 1) begin
                    m_en = 0; m_arm = 0; m_tmo = 1;
                end else begin
                    m_len++;
                end
            end else if (m_arm) begin
                if (m_hi) m_arm = 0;
                else begin
                    m_en = 1; m_len = 0; m_tmo = 0;
                end
            end
            if (lo_hist[$-1] == lo_hist[$-2]) m_lo = lo_hist[$-1];
            if (hi_hist[$-1] == hi_hist[$-2]) m_hi = hi_hist[$-1];
            lo_hist.push_back(lo_in); void'(lo_hist.pop_front());
            hi_hist.push_back(hi_in); void'(hi_hist.pop_front());
        end
    end

    // observed pulse statistics
    int  width = 0;
    int  pulses = 0;
    bit  en_prev = 0;

    always @(negedge clk) begin
        n_vec++;
        if (en !== m_en || tmo !== m_tmo) begin
            n_bad++;
            $display("FAIL %s cycle compare: en=%b tmo=%b expected en=%b tmo=%b",
                     cur_req, en, tmo, m_en, m_tmo);
        end
        if (en) width++;
        if (en && !en_prev) pulses++;
        en_prev = en;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        width = 0; pulses = 0;
    endtask

    task automatic drive(input bit lo, input bit hi);
        lo_in = lo; hi_in = hi;
    endtask

    initial begin
        wait_cyc(4);
        cur_req = "R1";
        check("R1 en in reset", en, 0);
        check("R1 tmo in reset", tmo, 0);
        rst_n = 1'b1;
        wait_cyc(20);
        check("R1 idle after reset", pulses, 0);

        // R2 fall, then R3/R5 slow rise with timeout
        cur_req = "R2";
        drive(0, 0);
        wait_cyc(10);
        check("R2 no pullup while low", en, 0);
        cur_req = "R5";
        clear_stats();
        drive(1, 0);
        wait_cyc(PULSE + 50);
        check("R3 one pulse on rise", pulses, 1);
        check("R5 timeout width", width, PULSE);
        check("R5 timeout status", tmo, 1);

        // R6 drop between thresholds after pulse does nothing
        cur_req = "R6";
        drive(1, 1); wait_cyc(10);
        clear_stats();
        drive(1, 0); wait_cyc(60);
        check("R6 no re-fire without fall", pulses, 0);
        check("R10 tmo held while idle", tmo, 1);
        drive(1, 1); wait_cyc(10);

        // R4 rise reaching high after 100 clocks
        cur_req = "R4";
        drive(0, 0); wait_cyc(10);
        clear_stats();
        drive(1, 0); wait_cyc(100);
        drive(1, 1); wait_cyc(20);
        check("R4 width ends at high", width, 100);
        check("R10 tmo cleared by new pulse", tmo, 0);

        // R7 line pulled low mid pulse, then re-rise
        cur_req = "R7";
        drive(0, 0); wait_cyc(10);
        clear_stats();
        drive(1, 0); wait_cyc(50);
        drive(0, 0); wait_cyc(20);
        check("R7 aborted width", width, 50);
        check("R7 off while low", en, 0);
        clear_stats();
        drive(1, 0); wait_cyc(PULSE + 20);
        check("R7 fresh full pulse", width, PULSE);
        drive(1, 1); wait_cyc(10);

        // R8 armed line jumps past both thresholds
        cur_req = "R8";
        drive(0, 0); wait_cyc(10);
        clear_stats();
        drive(1, 1); wait_cyc(20);
        drive(1, 0); wait_cyc(40);
        check("R8 no pulse on jump", pulses, 0);
        drive(1, 1); wait_cyc(10);

        // R9 glitch rejection and real two-cycle fall
        cur_req = "R9";
        clear_stats();
        drive(0, 1); wait_cyc(1);
        drive(1, 1); wait_cyc(30);
        check("R9 single glitch ignored", pulses, 0);
        drive(0, 0); wait_cyc(2);
        drive(1, 0); wait_cyc(60);
        check("R9 two-sample fall accepted", pulses, 1);
        drive(1, 1); wait_cyc(20);
        check("R11 idle at end", en, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule